// File: doc/BRIEF.md
# Packet Buffer Free-List Manager

This block owns a pool of fixed 128-byte packet-buffer blocks and hands them out to receive ports. It has no data storage of its own. It keeps a linked list of the unused block handles in a small link memory, and it holds the handle at the head of that list in a register. Leaving reset, it walks the whole pool once and chains block 0 to block 1, block 1 to block 2, and so on. It raises a busy flag during this walk. Only once the walk is complete does it serve any request.

A port asks for a block by raising a request with its port number. The answer comes back in the same cycle: a grant and the head handle. A port that frees a block presents the handle and the port number. That handle is pushed back at the head of the list, so the list behaves as a stack. Allocation and release may happen in the same cycle.

Each port has a usage counter. The counter is checked against two values programmed for that port: a reservation and a limit. The blocks not covered by any reservation form a shared pool. A separate combinational check tells whether a frame of a given byte length fits within a port's maximum frame size. That maximum is either the standard size or a programmable extended size that is enabled per port.

Top module: `buf_pool_mgr`

## Requirements
- R1: After reset, `init_busy` is high and `free_count` is 0 while the initialisation walk runs. During the walk, requests are refused and releases are ignored. When the walk ends, `init_busy` is low and `free_count` equals NUM_BLOCKS.
- R2: Blocks leave from the head of the list. After initialisation, successive grants return the handles 0, 1, 2, ... in ascending order, and each grant lowers `free_count` by one.
- R3: A released handle is pushed at the head of the list. The next grant returns the handle that was released most recently, and each release raises `free_count` by one.
- R4: When `free_count` is 0, `alloc_grant` stays low for every request, even from a port that is below its reservation.
- R5: When a grant and a release occur in the same cycle, the grant returns the old head and `free_count` does not change. The next grant returns the handle that was released.
- R6: A port whose usage is below its reservation is granted a block whenever the list is not empty, even if the shared pool is used up.
- R7: A port whose usage has reached both its limit and its reservation is refused, even when free blocks remain.
- R8: The shared pool has a size of NUM_BLOCKS minus the sum of all reservations, floored at 0. Its usage is the sum, over all ports, of the usage above each port's reservation. A port at or above its reservation is refused once the shared usage reaches the shared size.
- R9: For a port whose extended enable bit is 0, `len_oversize` is high exactly when ceil(len/128) exceeds 12 blocks. This is the block count of the standard frame sizes, 1518 and 1522 bytes.
- R10: For a port whose enable bit in `cfg_ext_en` is 1, the maximum frame size is `cfg_ext_max`, clamped to 4096 bytes. `len_oversize` is high exactly when ceil(len/128) exceeds ceil(max/128).
- R11: At all times `free_count` equals NUM_BLOCKS minus the number of blocks held by the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_busy | output | 1 | High while the list is being built |
| free_count | output | C_W | Number of blocks on the free list |
| alloc_req | input | 1 | Block request |
| alloc_port | input | P_W | Requesting port |
| alloc_grant | output | 1 | Request granted this cycle |
| alloc_handle | output | H_W | Granted block handle (head of list) |
| rel_valid | input | 1 | Release a block |
| rel_port | input | P_W | Port that held the released block |
| rel_handle | input | H_W | Handle being released |
| cfg_resv | input | NUM_PORTS x C_W | Per-port reservation in blocks |
| cfg_limit | input | NUM_PORTS x C_W | Per-port limit in blocks |
| cfg_ext_en | input | NUM_PORTS | Per-port extended frame size enable |
| cfg_ext_max | input | 13 | Extended maximum frame size in bytes |
| len_port | input | P_W | Port whose frame length is checked |
| len_bytes | input | 13 | Frame length in bytes |
| len_oversize | output | 1 | Frame needs more blocks than the port allows |

## Verification
The hardest state to reach is an empty free list while a port still sits below its reservation. When the reservations add up to no more than the pool, an empty list means every reservation is already in use. The bench fills the pool this way: first a port at its limit, then a port that exhausts the shared pool, then reservations that drain what is left. It then raises one port's reservation at run time, so that this port is below its reservation while the list is empty. A simultaneous allocate and release is applied partway through, and the handle order is tracked across it.

// File: rtl/fbm_pkg.sv
package fbm_pkg;

    localparam int BLK_BYTES     = 128;
    localparam int BLK_SHIFT     = 7;
    localparam int LEN_W         = 13;
    localparam int STD_MAX_BYTES = 1522;
    localparam int EXT_CAP_BYTES = 4096;
    localparam int NBLK_W        = LEN_W - BLK_SHIFT + 1;

    typedef enum logic [0:0] {
        FL_INIT = 1'b0,
        FL_RUN  = 1'b1
    } fl_state_e;

    function automatic logic [NBLK_W-1:0] blocks_of(input logic [LEN_W-1:0] nbytes);
        logic [LEN_W:0] t;
        t = {1'b0, nbytes} + (LEN_W+1)'(BLK_BYTES - 1);
        return t[LEN_W:BLK_SHIFT];
    endfunction

endpackage

// File: rtl/fbm_free_list.sv
module fbm_free_list
    import fbm_pkg::*;
#(
    parameter int NUM_BLOCKS = 64,
    parameter int H_W        = $clog2(NUM_BLOCKS),
    parameter int C_W        = $clog2(NUM_BLOCKS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pop,
    input  logic           push,
    input  logic [H_W-1:0] push_handle,
    output logic [H_W-1:0] head,
    output logic [C_W-1:0] count,
    output logic           busy
);

    localparam logic [H_W-1:0] LAST_IDX = H_W'(NUM_BLOCKS - 1);
    localparam logic [C_W-1:0] FULL_CNT = C_W'(NUM_BLOCKS);

    typedef struct packed {
        fl_state_e      state;
        logic [H_W-1:0] head;
        logic [C_W-1:0] count;
        logic [H_W-1:0] init_ptr;
    } fl_regs_t;

    fl_regs_t       fl_d, fl_q;
    logic [H_W-1:0] link_q [NUM_BLOCKS];
    logic           lk_we_d;
    logic [H_W-1:0] lk_addr_d;
    logic [H_W-1:0] lk_data_d;
    logic           pop_ok, push_ok;

    assign pop_ok  = (fl_q.state == FL_RUN) && pop && (fl_q.count != '0);
    assign push_ok = (fl_q.state == FL_RUN) && push && (fl_q.count != FULL_CNT);

    always_comb begin
        fl_d      = fl_q;
        lk_we_d   = 1'b0;
        lk_addr_d = '0;
        lk_data_d = '0;
        if (fl_q.state == FL_INIT) begin
            lk_we_d   = 1'b1;
            lk_addr_d = fl_q.init_ptr;
            lk_data_d = fl_q.init_ptr + 1'b1;
            if (fl_q.init_ptr == LAST_IDX) begin
                fl_d.state = FL_RUN;
                fl_d.head  = '0;
                fl_d.count = FULL_CNT;
            end else begin
                fl_d.init_ptr = fl_q.init_ptr + 1'b1;
            end
        end else if (pop_ok && push_ok) begin
            lk_we_d   = 1'b1;
            lk_addr_d = push_handle;
            lk_data_d = link_q[fl_q.head];
            fl_d.head = push_handle;
        end else if (pop_ok) begin
            fl_d.head  = link_q[fl_q.head];
            fl_d.count = fl_q.count - 1'b1;
        end else if (push_ok) begin
            lk_we_d    = 1'b1;
            lk_addr_d  = push_handle;
            lk_data_d  = fl_q.head;
            fl_d.head  = push_handle;
            fl_d.count = fl_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q.state    <= FL_INIT;
            fl_q.head     <= '0;
            fl_q.count    <= '0;
            fl_q.init_ptr <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    always_ff @(posedge clk) begin
        if (lk_we_d) begin
            link_q[lk_addr_d] <= lk_data_d;
        end
    end

    assign head  = fl_q.head;
    assign count = fl_q.count;
    assign busy  = (fl_q.state == FL_INIT);

    assert_busy_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (count == '0));

    assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    assert_pop_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && !push_ok) |=> (count == $past(count) - 1'b1));

    assert_both_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && push_ok) |=> (count == $past(count) && head == $past(push_handle)));

endmodule

// File: rtl/fbm_port_quota.sv
module fbm_port_quota #(
    parameter int NUM_PORTS  = 4,
    parameter int NUM_BLOCKS = 64,
    parameter int P_W        = $clog2(NUM_PORTS),
    parameter int C_W        = $clog2(NUM_BLOCKS + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [P_W-1:0]                 req_port,
    input  logic                           take,
    input  logic                           give,
    input  logic [P_W-1:0]                 give_port,
    input  logic [NUM_PORTS-1:0][C_W-1:0]  cfg_resv,
    input  logic [NUM_PORTS-1:0][C_W-1:0]  cfg_limit,
    output logic                           allow
);

    localparam int S_W = C_W + P_W + 1;

    typedef struct packed {
        logic [NUM_PORTS-1:0][C_W-1:0] used;
    } pq_regs_t;

    pq_regs_t       pq_d, pq_q;
    logic [S_W-1:0] excess [NUM_PORTS];
    logic [S_W-1:0] resv_sum, shared_used, shared_size, used_total;
    logic [C_W-1:0] used_sel;

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_excess
        assign excess[gi] = (pq_q.used[gi] > cfg_resv[gi])
                          ? S_W'(pq_q.used[gi] - cfg_resv[gi]) : '0;
    end

    always_comb begin
        resv_sum    = '0;
        shared_used = '0;
        used_total  = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            resv_sum    = resv_sum + S_W'(cfg_resv[i]);
            shared_used = shared_used + excess[i];
            used_total  = used_total + S_W'(pq_q.used[i]);
        end
        shared_size = (resv_sum >= S_W'(NUM_BLOCKS)) ? '0 : S_W'(NUM_BLOCKS) - resv_sum;
        used_sel    = pq_q.used[req_port];
        allow       = (used_sel < cfg_resv[req_port])
                   || ((used_sel < cfg_limit[req_port]) && (shared_used < shared_size));
    end

    always_comb begin
        pq_d = pq_q;
        for (int i = 0; i < NUM_PORTS; i++) begin
            pq_d.used[i] = pq_q.used[i]
                         + C_W'(take && (req_port == P_W'(i)))
                         - C_W'(give && (give_port == P_W'(i)) && (pq_q.used[i] != '0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pq_q <= '0;
        end else begin
            pq_q <= pq_d;
        end
    end

    assert_take_in_quota_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((pq_q.used[req_port] < cfg_limit[req_port])
               || (pq_q.used[req_port] < cfg_resv[req_port])));

    assert_held_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        used_total <= S_W'(NUM_BLOCKS));

endmodule

// File: rtl/fbm_len_check.sv
module fbm_len_check
    import fbm_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int P_W       = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [P_W-1:0]       len_port,
    input  logic [LEN_W-1:0]     len_bytes,
    input  logic [NUM_PORTS-1:0] cfg_ext_en,
    input  logic [LEN_W-1:0]     cfg_ext_max,
    output logic                 oversize
);

    localparam logic [LEN_W-1:0] STD_MAX = LEN_W'(STD_MAX_BYTES);
    localparam logic [LEN_W-1:0] EXT_CAP = LEN_W'(EXT_CAP_BYTES);

    logic [LEN_W-1:0]  max_bytes;
    logic [NBLK_W-1:0] need_blk, max_blk;
    logic              ext_sel;

    always_comb begin
        ext_sel   = cfg_ext_en[len_port];
        max_bytes = ext_sel ? ((cfg_ext_max > EXT_CAP) ? EXT_CAP : cfg_ext_max) : STD_MAX;
        need_blk  = blocks_of(len_bytes);
        max_blk   = blocks_of(max_bytes);
        oversize  = need_blk > max_blk;
    end

    assert_std_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (oversize && !ext_sel) |-> (len_bytes > LEN_W'(12 * BLK_BYTES)));

    assert_ext_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && len_bytes > EXT_CAP) |-> oversize);

endmodule

// File: rtl/buf_pool_mgr.sv
module buf_pool_mgr
    import fbm_pkg::*;
#(
    parameter int NUM_BLOCKS = 64,
    parameter int NUM_PORTS  = 4,
    parameter int H_W        = $clog2(NUM_BLOCKS),
    parameter int C_W        = $clog2(NUM_BLOCKS + 1),
    parameter int P_W        = $clog2(NUM_PORTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic                          init_busy,
    output logic [C_W-1:0]                free_count,
    input  logic                          alloc_req,
    input  logic [P_W-1:0]                alloc_port,
    output logic                          alloc_grant,
    output logic [H_W-1:0]                alloc_handle,
    input  logic                          rel_valid,
    input  logic [P_W-1:0]                rel_port,
    input  logic [H_W-1:0]                rel_handle,
    input  logic [NUM_PORTS-1:0][C_W-1:0] cfg_resv,
    input  logic [NUM_PORTS-1:0][C_W-1:0] cfg_limit,
    input  logic [NUM_PORTS-1:0]          cfg_ext_en,
    input  logic [LEN_W-1:0]              cfg_ext_max,
    input  logic [P_W-1:0]                len_port,
    input  logic [LEN_W-1:0]              len_bytes,
    output logic                          len_oversize
);

    logic quota_ok;
    logic rel_ok;

    assign alloc_grant = alloc_req && !init_busy && (free_count != '0) && quota_ok;
    assign rel_ok      = rel_valid && !init_busy;

    fbm_free_list #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .H_W        (H_W),
        .C_W        (C_W)
    ) u_list (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop         (alloc_grant),
        .push        (rel_ok),
        .push_handle (rel_handle),
        .head        (alloc_handle),
        .count       (free_count),
        .busy        (init_busy)
    );

    fbm_port_quota #(
        .NUM_PORTS  (NUM_PORTS),
        .NUM_BLOCKS (NUM_BLOCKS),
        .P_W        (P_W),
        .C_W        (C_W)
    ) u_quota (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_port  (alloc_port),
        .take      (alloc_grant),
        .give      (rel_ok),
        .give_port (rel_port),
        .cfg_resv  (cfg_resv),
        .cfg_limit (cfg_limit),
        .allow     (quota_ok)
    );

    fbm_len_check #(
        .NUM_PORTS (NUM_PORTS),
        .P_W       (P_W)
    ) u_len (
        .clk         (clk),
        .rst_n       (rst_n),
        .len_port    (len_port),
        .len_bytes   (len_bytes),
        .cfg_ext_en  (cfg_ext_en),
        .cfg_ext_max (cfg_ext_max),
        .oversize    (len_oversize)
    );

    assert_grant_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |-> (free_count != '0 && !init_busy));

    assert_release_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |=> (free_count == '0 || free_count == C_W'(NUM_BLOCKS)));

endmodule

// File: tb/buf_pool_mgr_tb_top.sv
module buf_pool_mgr_tb_top;

    localparam int NB  = 64;
    localparam int NP  = 4;
    localparam int HW  = $clog2(NB);
    localparam int CW  = $clog2(NB + 1);
    localparam int PW  = $clog2(NP);
    localparam int LW  = 13;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 init_busy;
    logic [CW-1:0]        free_count;
    logic                 alloc_req = 1'b0;
    logic [PW-1:0]        alloc_port = '0;
    logic                 alloc_grant;
    logic [HW-1:0]        alloc_handle;
    logic                 rel_valid = 1'b0;
    logic [PW-1:0]        rel_port = '0;
    logic [HW-1:0]        rel_handle = '0;
    logic [NP-1:0][CW-1:0] cfg_resv;
    logic [NP-1:0][CW-1:0] cfg_limit;
    logic [NP-1:0]        cfg_ext_en = '0;
    logic [LW-1:0]        cfg_ext_max = '0;
    logic [PW-1:0]        len_port = '0;
    logic [LW-1:0]        len_bytes = '0;
    logic                 len_oversize;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [HW-1:0] p2_handles [NB];
    int            p2_count = 0;

    always #2.5 clk = ~clk;

    buf_pool_mgr #(.NUM_BLOCKS(NB), .NUM_PORTS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .init_busy(init_busy), .free_count(free_count),
        .alloc_req(alloc_req), .alloc_port(alloc_port), .alloc_grant(alloc_grant),
        .alloc_handle(alloc_handle), .rel_valid(rel_valid), .rel_port(rel_port),
        .rel_handle(rel_handle), .cfg_resv(cfg_resv), .cfg_limit(cfg_limit),
        .cfg_ext_en(cfg_ext_en), .cfg_ext_max(cfg_ext_max), .len_port(len_port),
        .len_bytes(len_bytes), .len_oversize(len_oversize)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycle(input bit req, input int ap, input bit rel, input int rp,
                         input int rh, output bit g, output int h);
        @(negedge clk);
        alloc_req  = req;  alloc_port = PW'(ap);
        rel_valid  = rel;  rel_port   = PW'(rp);  rel_handle = HW'(rh);
        #1;
        g = alloc_grant;
        h = int'(alloc_handle);
        @(posedge clk);
        #1;
        alloc_req = 1'b0;
        rel_valid = 1'b0;
    endtask

    task automatic alloc_expect(input string tag, input int port, input bit eg, input int eh);
        bit g; int h;
        cycle(1'b1, port, 1'b0, 0, 0, g, h);
        chk({tag, " grant"}, int'(g), int'(eg));
        if (eg && eh >= 0) chk({tag, " handle"}, h, eh);
    endtask

    task automatic release_blk(input int port, input int hd);
        bit g; int h;
        cycle(1'b0, 0, 1'b1, port, hd, g, h);
    endtask

    task automatic test_init_R1();
        int waited = 0;
        bit g; int h;
        #1;
        chk("R1 busy at reset", int'(init_busy), 1);
        chk("R1 count at reset", int'(free_count), 0);
        rst_n = 1'b1;
        cycle(1'b1, 0, 1'b0, 0, 0, g, h);
        chk("R1 refused while busy", int'(g), 0);
        release_blk(0, 5);
        while (init_busy && waited < 200) begin
            @(posedge clk); #1; waited++;
        end
        chk("R1 busy clears", int'(init_busy), 0);
        chk("R1 full count, release ignored", int'(free_count), NB);
    endtask

    task automatic test_lifo_R2();
        for (int i = 0; i < 3; i++) alloc_expect("R2 ascending", 0, 1'b1, i);
        chk("R2 count after three", int'(free_count), NB - 3);
    endtask

    task automatic test_release_R3();
        release_blk(0, 1);
        chk("R3 count after release", int'(free_count), NB - 2);
        alloc_expect("R3 reuse latest", 0, 1'b1, 1);
    endtask

    task automatic test_both_R5();
        bit g; int h;
        cycle(1'b1, 0, 1'b1, 0, 0, g, h);
        chk("R5 grant", int'(g), 1);
        chk("R5 old head", h, 3);
        chk("R5 count unchanged", int'(free_count), NB - 3);
        alloc_expect("R5 released next", 0, 1'b1, 0);
    endtask

    task automatic test_limit_R7();
        alloc_expect("R7 first", 1, 1'b1, 4);
        alloc_expect("R7 second", 1, 1'b1, 5);
        alloc_expect("R7 at limit", 1, 1'b0, -1);
        chk("R7 count", int'(free_count), NB - 6);
    endtask

    task automatic test_shared_R8();
        bit g; int h;
        for (int i = 0; i < 49; i++) begin
            cycle(1'b1, 2, 1'b0, 0, 0, g, h);
            chk("R8 port2 within reservation+shared", int'(g), 1);
            p2_handles[p2_count] = HW'(h);
            p2_count++;
        end
        alloc_expect("R8 shared exhausted", 2, 1'b0, -1);
        chk("R8 count", int'(free_count), 9);
    endtask

    task automatic test_resv_R6();
        for (int i = 0; i < 4; i++) alloc_expect("R6 port3 reservation", 3, 1'b1, -1);
        alloc_expect("R8 port3 past reservation", 3, 1'b0, -1);
        for (int i = 0; i < 5; i++) alloc_expect("R6 port0 reservation", 0, 1'b1, -1);
        chk("R6 count drained", int'(free_count), 0);
    endtask

    task automatic test_empty_R4();
        cfg_resv[0] = CW'(20);
        alloc_expect("R4 empty list", 0, 1'b0, -1);
        chk("R4 count zero", int'(free_count), 0);
    endtask

    task automatic test_count_R11();
        int hd = int'(p2_handles[10]);
        release_blk(2, hd);
        chk("R11 count after release", int'(free_count), 1);
        alloc_expect("R11 refill", 0, 1'b1, hd);
        chk("R11 count after refill", int'(free_count), 0);
    endtask

    task automatic len_case(input string tag, input int port, input int nbytes, input bit exp);
        @(negedge clk);
        len_port  = PW'(port);
        len_bytes = LW'(nbytes);
        #1;
        chk(tag, int'(len_oversize), int'(exp));
    endtask

    task automatic test_len_R9_R10();
        cfg_ext_en  = 4'b0010;
        cfg_ext_max = LW'(4096);
        len_case("R9 1518 fits", 0, 1518, 1'b0);
        len_case("R9 1536 fits", 0, 1536, 1'b0);
        len_case("R9 1537 over", 0, 1537, 1'b1);
        len_case("R10 4096 fits", 1, 4096, 1'b0);
        len_case("R10 4097 over", 1, 4097, 1'b1);
        cfg_ext_max = LW'(2000);
        len_case("R10 2048 fits", 1, 2048, 1'b0);
        len_case("R10 2049 over", 1, 2049, 1'b1);
        cfg_ext_max = LW'(5000);
        len_case("R10 clamp 4097 over", 1, 4097, 1'b1);
        len_case("R9 other port standard", 2, 2000, 1'b1);
    endtask

    initial begin
        cfg_resv[0] = CW'(9);  cfg_limit[0] = CW'(40);
        cfg_resv[1] = CW'(2);  cfg_limit[1] = CW'(2);
        cfg_resv[2] = CW'(4);  cfg_limit[2] = CW'(64);
        cfg_resv[3] = CW'(4);  cfg_limit[3] = CW'(40);
        repeat (3) @(posedge clk);
        test_init_R1();
        test_lifo_R2();
        test_release_R3();
        test_both_R5();
        test_limit_R7();
        test_shared_R8();
        test_resv_R6();
        test_empty_R4();
        test_count_R11();
        test_len_R9_R10();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule